// File: doc/BRIEF.md
# Wake-Up Interval Timekeeper

This block keeps time of day from a 32.768 kHz timebase and wakes a sleeping core at programmed intervals. A prescaler divides the timebase into 1/128-second steps. These steps drive a chain of four counters: a 7-bit sub-second count, then seconds, minutes and hours. Each counter carries into the next when it wraps. An interval engine counts events of a selectable unit and raises a sticky interrupt flag when a programmed count is reached. It also emits a one-cycle wake-up pulse that a power-down controller can use.

Software reaches the block through a small synchronous register bus that runs in the timebase clock domain. The run bit in the control register has three jobs:

- It starts the clock when set.
- While it is clear, the time registers can be written.
- When it falls, the time is cleared after it has been low for a full timebase period.

There are two resets. The asynchronous power-on reset `rst_n` clears everything. The core reset request `core_rst_i` has no effect while the timekeeper runs, so the time survives a restart of the processor.

Top module: `wakeup_rtc`

## Requirements
- R1: After power-on reset every register reads 0, `irq_o` is 0 and `wake_o` is 0.
- R2: While the run bit is 1, the sub-second count advances once every PRESC_DIV clock cycles. It wraps from 127 to 0 and carries one into seconds at that wrap. While the run bit is 0 nothing advances.
- R3: Seconds and minutes each count 0 to 59. Each wrap to 0 carries one into the next field.
- R4: Hours count 0 to 23 and then wrap to 0, so 23:59:59 and sub-second 127 roll over to all zeros.
- R5: A bus write to a time register takes effect only while the run bit is 0. While the bit is 1 the write is ignored.
- R6: When the run bit goes from 1 to 0, all four time fields clear at the following clock edge, once the bit has been low for a full period. Time writes made after that point are kept.
- R7: A time write whose value is not below the field's modulus (128, 60, 60, 24) stores 0.
- R8: A core reset request has no effect while the run bit is 1. While the bit is 0, the request returns every register and the flag to their power-on values.
- R9: Control bits [3:2] select the interval unit: 0 = 1/128 s, 1 = second, 2 = minute, 3 = hour. With the run bit and the interval-enable bit (control bit 1) both set, and an interval count N > 0, the flag sets on the Nth unit event. The unit counter then reloads to 0 and repeats.
- R10: With N = 0, or with interval-enable at 0, the flag never sets.
- R11: The flag stays set until a bus write to address 6 with data bit 0 at 1. `irq_o` shows the flag, and address 6 reads it back in bit 0.
- R12: `wake_o` is high for exactly the one cycle after the edge at which the flag sets.
- R13: The register map is as follows, with the upper bits reading 0:

  | Address | Contents |
  |---|---|
  | 0 | control: bit 0 run, bit 1 interval enable, bits [3:2] unit |
  | 1 | sub-second |
  | 2 | seconds |
  | 3 | minutes |
  | 4 | hours |
  | 5 | interval count N |
  | 6 | flag |
  | 7 | current interval unit counter |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| core_rst_i | input | 1 | Synchronous core reset request; obeys the retention rule |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interval flag |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
A corrupted prescaler or carry term shows at the ports within one rollover. A preload of 23:59:59.127 must read all zeros exactly PRESC_DIV edges after the run bit is set, and one edge earlier it must still read the preload. An interval counter that fails to reload, or a flag that clears itself, shows up on the second expiry: with N = 3 on the finest unit, that expiry must fall exactly 12 edges after the first. A broken retention or clear rule shows up at the first read after the core reset pulse or after the run bit falls.

// File: rtl/wakeup_rtc_pkg.sv
package wakeup_rtc_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    UNIT_TICK = 2'd0,
    UNIT_SEC  = 2'd1,
    UNIT_MIN  = 2'd2,
    UNIT_HOUR = 2'd3
  } unit_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SUB   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MIN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HOUR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MATCH = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd6;
  localparam logic [ADDR_W-1:0] A_UCNT  = 3'd7;

endpackage

// File: rtl/wakeup_rtc_presc.sv
module wakeup_rtc_presc #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the divider rests at zero while stopped
  p_presc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/wakeup_rtc_field.sv
module wakeup_rtc_field #(
  parameter int MOD    = 60,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [$clog2(MOD)-1:0] value_o,
  output logic              carry_o
);
  localparam int W = $clog2(MOD);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q, val_d;
  logic         in_range;

  assign in_range = (wdata_i < DATA_W'(MOD));
  assign carry_o  = inc_i && (val_q == TOP);
  assign value_o  = val_q;

  always_comb begin
    val_d = val_q;
    if (wr_i)         val_d = in_range ? wdata_i[W-1:0] : '0;
    else if (clr_i)   val_d = '0;
    else if (carry_o) val_d = '0;
    else if (inc_i)   val_d = val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  // R7: a field never holds a value at or above its modulus
  p_field_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, val_q} < (W+1)'(MOD)));

  // R3: a field at its top value rolls to zero on an increment
  p_field_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q == TOP && inc_i && !wr_i && !clr_i) |=> (val_q == '0));

endmodule

// File: rtl/wakeup_rtc_itv.sv
module wakeup_rtc_itv
  import wakeup_rtc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr_i,
  input  logic              run_i,
  input  logic              en_i,
  input  unit_e             unit_i,
  input  logic [3:0]        evt_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic              flag_clr_i,
  output logic              flag_o,
  output logic              wake_o,
  output logic [DATA_W-1:0] cnt_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              flag_q, flag_d;
  logic              wake_q, wake_d;
  logic              evt, expire, active;

  assign active = run_i && en_i && (match_i != '0);
  assign evt    = evt_i[unit_i];
  assign expire = active && evt && ((cnt_q + DATA_W'(1)) == match_i);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    wake_d = expire;
    if (!run_i || !en_i) cnt_d = '0;
    else if (expire)     cnt_d = '0;
    else if (evt)        cnt_d = cnt_q + DATA_W'(1);
    if (expire)          flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    if (soft_clr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
      wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      wake_q <= wake_d;
    end
  end

  assign flag_o = flag_q;
  assign wake_o = wake_q;
  assign cnt_o  = cnt_q;

  // R11: the flag persists until a clear or a core reset
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i && !soft_clr_i) |=> flag_q);

  // R12: the wake pulse lasts one cycle and comes with the flag
  p_wake_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  p_wake_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> flag_q);

  // R10: with a zero count no expiry ever reaches the outputs
  p_zero_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i == '0 && !flag_q && !soft_clr_i) |=> !flag_q);

endmodule

// File: rtl/wakeup_rtc.sv
module wakeup_rtc
  import wakeup_rtc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PRESC_DIV = 256,
  parameter int SUB_MOD   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SUB_W = $clog2(SUB_MOD);
  localparam int SEC_W = $clog2(60);
  localparam int HR_W  = $clog2(24);

  // control state
  logic              run_q, run_d;
  logic              itv_en_q, itv_en_d;
  unit_e             unit_q, unit_d;
  logic [DATA_W-1:0] match_q, match_d;
  logic              run_prev_q;

  logic soft_rst, time_clr, tm_wr_ok, ctrl_wr, flag_clr;
  logic tick;
  logic c_sub, c_sec, c_min, c_hr;
  logic [SUB_W-1:0] tm_sub;
  logic [SEC_W-1:0] tm_sec, tm_min;
  logic [HR_W-1:0]  tm_hr;
  logic [DATA_W-1:0] ucnt;
  logic              flag;

  assign soft_rst = core_rst_i && !run_q;
  assign time_clr = soft_rst || (run_prev_q && !run_q);
  assign tm_wr_ok = bus_wr_i && !run_q && !soft_rst;
  assign ctrl_wr  = bus_wr_i && (bus_addr_i == A_CTRL);
  assign flag_clr = bus_wr_i && (bus_addr_i == A_FLAG) && bus_wdata_i[0];

  always_comb begin
    run_d    = run_q;
    itv_en_d = itv_en_q;
    unit_d   = unit_q;
    match_d  = match_q;
    if (soft_rst) begin
      run_d    = 1'b0;
      itv_en_d = 1'b0;
      unit_d   = UNIT_TICK;
      match_d  = '0;
    end else begin
      if (ctrl_wr) begin
        run_d    = bus_wdata_i[0];
        itv_en_d = bus_wdata_i[1];
        unit_d   = unit_e'(bus_wdata_i[3:2]);
      end
      if (bus_wr_i && bus_addr_i == A_MATCH) match_d = bus_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      itv_en_q   <= 1'b0;
      unit_q     <= UNIT_TICK;
      match_q    <= '0;
      run_prev_q <= 1'b0;
    end else begin
      run_q      <= run_d;
      itv_en_q   <= itv_en_d;
      unit_q     <= unit_d;
      match_q    <= match_d;
      run_prev_q <= run_q;
    end
  end

  wakeup_rtc_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .tick_o(tick)
  );

  wakeup_rtc_field #(.MOD(SUB_MOD), .DATA_W(DATA_W)) u_sub (
    .clk(clk), .rst_n(rst_n), .clr_i(time_clr),
    .wr_i(tm_wr_ok && bus_addr_i == A_SUB), .wdata_i(bus_wdata_i),
    .inc_i(tick), .value_o(tm_sub), .carry_o(c_sub)
  );

  wakeup_rtc_field #(.MOD(60), .DATA_W(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr_i(time_clr),
    .wr_i(tm_wr_ok && bus_addr_i == A_SEC), .wdata_i(bus_wdata_i),
    .inc_i(c_sub), .value_o(tm_sec), .carry_o(c_sec)
  );

  wakeup_rtc_field #(.MOD(60), .DATA_W(DATA_W)) u_min (
    .clk(clk), .rst_n(rst_n), .clr_i(time_clr),
    .wr_i(tm_wr_ok && bus_addr_i == A_MIN), .wdata_i(bus_wdata_i),
    .inc_i(c_sec), .value_o(tm_min), .carry_o(c_min)
  );

  wakeup_rtc_field #(.MOD(24), .DATA_W(DATA_W)) u_hour (
    .clk(clk), .rst_n(rst_n), .clr_i(time_clr),
    .wr_i(tm_wr_ok && bus_addr_i == A_HOUR), .wdata_i(bus_wdata_i),
    .inc_i(c_min), .value_o(tm_hr), .carry_o(c_hr)
  );

  wakeup_rtc_itv #(.DATA_W(DATA_W)) u_itv (
    .clk(clk), .rst_n(rst_n), .soft_clr_i(soft_rst),
    .run_i(run_q), .en_i(itv_en_q), .unit_i(unit_q),
    .evt_i({c_min, c_sec, c_sub, tick}), .match_i(match_q),
    .flag_clr_i(flag_clr), .flag_o(flag), .wake_o(wake_o), .cnt_o(ucnt)
  );

  assign irq_o = flag;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = DATA_W'({unit_q, itv_en_q, run_q});
      A_SUB:   bus_rdata_o = DATA_W'(tm_sub);
      A_SEC:   bus_rdata_o = DATA_W'(tm_sec);
      A_MIN:   bus_rdata_o = DATA_W'(tm_min);
      A_HOUR:  bus_rdata_o = DATA_W'(tm_hr);
      A_MATCH: bus_rdata_o = match_q;
      A_FLAG:  bus_rdata_o = DATA_W'(flag);
      A_UCNT:  bus_rdata_o = ucnt;
      default: bus_rdata_o = '0;
    endcase
  end

  // R6: a stopped, settled timekeeper holds its time without bus traffic
  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !run_prev_q && !bus_wr_i && !core_rst_i)
      |=> $stable({tm_hr, tm_min, tm_sec, tm_sub}));

  // R8: a core reset while stopped returns control and time to zero
  p_soft_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_i && !run_q) |=> (!run_q && !irq_o && tm_hr == '0 && tm_sub == '0));

  // R4: the hour chain never carries out past 23:59:59
  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_hr |=> (tm_hr == '0 && tm_min == '0));

endmodule

// File: tb/wakeup_rtc_tb.sv
`timescale 1ns/1ps
module wakeup_rtc_tb;
  localparam int DW  = 8;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_rst = 1'b0;
  logic          wr = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, wake;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wakeup_rtc #(.DATA_W(DW), .PRESC_DIV(DIV), .SUB_MOD(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_rst_i(core_rst),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bwr(input logic [2:0] a, input int d);
    addr = a; wdata = DW'(d); wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [2:0] a, output int d);
    addr = a;
    #0.1;
    d = int'(rdata);
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input int exp);
    int v;
    brd(a, v);
    chk(req, v, exp);
  endtask

  task automatic stop_all();
    bwr(3'd0, 0);
    edges(1);
    bwr(3'd6, 1);
  endtask

  task automatic preload(input int h, input int m, input int s, input int ss);
    bwr(3'd4, h); bwr(3'd3, m); bwr(3'd2, s); bwr(3'd1, ss);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) chk_reg("R1 reg", 3'(a), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 wake", int'(wake), 0);
  endtask

  task automatic t_map();
    bwr(3'd0, 8'h0E);
    chk_reg("R13 ctrl readback", 3'd0, 8'h0E);
    bwr(3'd5, 8'hA5);
    chk_reg("R13 match readback", 3'd5, 8'hA5);
    bwr(3'd0, 0);
    edges(1);
  endtask

  task automatic t_prescale();
    stop_all();
    bwr(3'd0, 1);
    edges(DIV*5 - 1);
    chk_reg("R2 sub before step", 3'd1, 4);
    edges(1);
    chk_reg("R2 sub after step", 3'd1, 5);
    stop_all();
    preload(0, 0, 0, 127);
    bwr(3'd0, 1);
    edges(DIV);
    chk_reg("R2 sub wrap", 3'd1, 0);
    chk_reg("R2 carry to sec", 3'd2, 1);
    stop_all();
    preload(0, 0, 0, 9);
    edges(3*DIV);
    chk_reg("R2 stopped holds", 3'd1, 9);
  endtask

  task automatic t_chain();
    stop_all();
    preload(0, 0, 59, 127);
    bwr(3'd0, 1);
    edges(DIV);
    chk_reg("R3 sec wrap", 3'd2, 0);
    chk_reg("R3 min carry", 3'd3, 1);
    stop_all();
    preload(0, 59, 59, 127);
    bwr(3'd0, 1);
    edges(DIV);
    chk_reg("R3 min wrap", 3'd3, 0);
    chk_reg("R3 hour carry", 3'd4, 1);
  endtask

  task automatic t_day_wrap();
    stop_all();
    preload(23, 59, 59, 127);
    bwr(3'd0, 1);
    edges(DIV - 1);
    chk_reg("R4 hour before", 3'd4, 23);
    chk_reg("R4 sub before", 3'd1, 127);
    edges(1);
    chk_reg("R4 hour wrap", 3'd4, 0);
    chk_reg("R4 min wrap", 3'd3, 0);
    chk_reg("R4 sec wrap", 3'd2, 0);
    chk_reg("R4 sub wrap", 3'd1, 0);
  endtask

  task automatic t_write_gate();
    stop_all();
    bwr(3'd0, 1);
    bwr(3'd2, 30);
    bwr(3'd4, 7);
    chk_reg("R5 sec write ignored", 3'd2, 0);
    chk_reg("R5 hour write ignored", 3'd4, 0);
    stop_all();
    bwr(3'd2, 30);
    chk_reg("R5 sec write stopped", 3'd2, 30);
  endtask

  task automatic t_enable_clear();
    stop_all();
    preload(5, 6, 7, 8);
    bwr(3'd0, 1);
    edges(2);
    bwr(3'd0, 0);
    chk_reg("R6 not yet cleared", 3'd4, 5);
    edges(1);
    chk_reg("R6 hour cleared", 3'd4, 0);
    chk_reg("R6 min cleared", 3'd3, 0);
    chk_reg("R6 sec cleared", 3'd2, 0);
    chk_reg("R6 sub cleared", 3'd1, 0);
    bwr(3'd2, 7);
    edges(3);
    chk_reg("R6 later write kept", 3'd2, 7);
  endtask

  task automatic t_range();
    stop_all();
    bwr(3'd3, 60);
    chk_reg("R7 min 60", 3'd3, 0);
    bwr(3'd4, 24);
    chk_reg("R7 hour 24", 3'd4, 0);
    bwr(3'd1, 128);
    chk_reg("R7 sub 128", 3'd1, 0);
    bwr(3'd3, 59);
    chk_reg("R7 min 59", 3'd3, 59);
  endtask

  task automatic t_core_rst();
    stop_all();
    preload(3, 4, 5, 6);
    bwr(3'd0, 1);
    edges(3);
    core_rst = 1'b1;
    edges(1);
    core_rst = 1'b0;
    chk_reg("R8 run kept hour", 3'd4, 3);
    chk_reg("R8 run kept min", 3'd3, 4);
    chk_reg("R8 run kept sec", 3'd2, 5);
    chk_reg("R8 run kept ctrl", 3'd0, 1);
    stop_all();
    preload(3, 4, 5, 6);
    bwr(3'd5, 7);
    bwr(3'd0, 8'h0A);
    core_rst = 1'b1;
    edges(1);
    core_rst = 1'b0;
    chk_reg("R8 stopped ctrl", 3'd0, 0);
    chk_reg("R8 stopped hour", 3'd4, 0);
    chk_reg("R8 stopped sub", 3'd1, 0);
    chk_reg("R8 stopped match", 3'd5, 0);
  endtask

  task automatic t_interval();
    stop_all();
    bwr(3'd5, 3);
    bwr(3'd0, 8'h03);
    edges(3*DIV - 1);
    chk("R9 flag before expiry", int'(irq), 0);
    edges(1);
    chk("R9 flag at expiry", int'(irq), 1);
    chk("R12 wake at expiry", int'(wake), 1);
    chk_reg("R9 counter reloaded", 3'd7, 0);
    bwr(3'd6, 1);
    chk("R12 wake one cycle", int'(wake), 0);
    chk("R11 flag cleared", int'(irq), 0);
    edges(3*DIV - 2);
    chk("R9 no early repeat", int'(irq), 0);
    edges(1);
    chk("R9 repeat expiry", int'(irq), 1);
    chk("R12 wake repeat", int'(wake), 1);
    edges(2);
    chk("R11 flag sticky", int'(irq), 1);
    chk_reg("R11 flag readback", 3'd6, 1);
    bwr(3'd6, 0);
    chk("R11 write zero keeps flag", int'(irq), 1);
  endtask

  task automatic t_interval_sec();
    stop_all();
    bwr(3'd1, 127);
    bwr(3'd5, 2);
    bwr(3'd0, 8'h07);
    edges(DIV + 128*DIV - 1);
    chk("R9 sec unit before", int'(irq), 0);
    edges(1);
    chk("R9 sec unit expiry", int'(irq), 1);
  endtask

  task automatic t_interval_off();
    stop_all();
    bwr(3'd5, 0);
    bwr(3'd0, 8'h03);
    edges(40);
    chk("R10 zero count silent", int'(irq), 0);
    stop_all();
    bwr(3'd5, 1);
    bwr(3'd0, 8'h01);
    edges(40);
    chk("R10 disabled silent", int'(irq), 0);
    chk_reg("R10 counter idle", 3'd7, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_map();
    t_prescale();
    t_chain();
    t_day_wrap();
    t_write_gate();
    t_enable_clear();
    t_range();
    t_core_rst();
    t_interval();
    t_interval_sec();
    t_interval_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule